// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The controller gathers 24 interrupt sources: one fast external line, four ordinary external lines and nineteen internal peripheral lines such as timers, a watchdog and DMA engines. All request lines are treated as asynchronous and pass through a two-stage synchronizer. External lines are edge-sensitive and latched until the CPU acknowledges them. Internal lines are level-sensitive. Each source has its own enable bit and a 3-bit priority level, which gives eight levels. The highest-priority pending enabled request is presented on `irq_o` together with its source number.

The fast line does not take part in level arbitration. It drives `fiq_o` directly, gated only by its enable bit. When the CPU acknowledges the normal request, the winning level is pushed as the current service level. From then on only requests at a strictly higher level can raise `irq_o`. The end-of-service strobe pops back to the level that was active before, so nested service works up to eight deep.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq_o` and `fiq_o` are low and every register reads zero, so all sources are disabled at level 0.
- R2: Register word 0 holds the enable bits, with bit j enabling source j. Word 1+j/8 holds the level of source j in bits 3*(j%8)+2 down to 3*(j%8). Writes are accepted when `reg_we_i` is high, and `reg_rdata_o` returns the addressed word combinationally.
- R3: A source whose enable bit is clear never raises `irq_o`, even while its request is pending.
- R4: Source numbering is fixed. Id 0 is `fiq_req_i`, ids 1 to 4 are `ext_req_i[0..3]` and ids 5 to 23 are `int_req_i[0..18]`. Among eligible sources the one with the highest level wins, and its id appears on `irq_id_o`.
- R5: Among eligible sources of equal level, the lowest id wins.
- R6: `fiq_o` follows the synchronized fast request whenever enable bit 0 is set, two clock edges after the input. It is independent of levels, arbitration and the service stack.
- R7: A rising edge on an external line latches that source as pending. It stays pending after the line falls, until the source is acknowledged. A line held high does not re-request after it has been acknowledged.
- R8: Internal requests are level-sensitive. Dropping the line before acknowledge withdraws the request.
- R9: `ack_i` while `irq_o` is high pushes the winner's level. While that level is current, only strictly higher levels raise `irq_o`.
- R10: `eoi_i` pops the current level, so arbitration returns to the previously active level, or to none.
- R11: An internal request reaches `irq_o` on the second clock edge after it rises. An external request reaches `irq_o` on the third.
- R12: `ack_i` while `irq_o` is low, and `eoi_i` with nothing in service, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fiq_req_i | input | 1 | Fast external request (id 0) |
| ext_req_i | input | 4 | Edge-type external requests (ids 1-4) |
| int_req_i | input | 19 | Level-type internal requests (ids 5-23) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Register read data |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | 5 | Id of the winning source |
| fiq_o | output | 1 | Fast interrupt request |
| ack_i | input | 1 | CPU takes the presented interrupt |
| eoi_i | input | 1 | CPU ends service of the current level |

## Verification
The hardest situation to reach is nested service. That means a second, higher-level request preempting an interrupt already in service, while an equal-level request waits. Then end-of-service must uncover the waiting requests in the right order. The stimulus acknowledges a low-level internal source first and raises a higher level and an equal higher level on top of it. It then pops the stack step by step and checks which id reappears at each step. A zero-level source raised after a stray acknowledge shows whether that acknowledge pushed anything onto the stack.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int N_SRC  = 24;
  localparam int N_EXT  = 4;
  localparam int N_INT  = N_SRC - 1 - N_EXT;
  localparam int N_LVL  = 8;
  localparam int LVL_W  = $clog2(N_LVL);
  localparam int ID_W   = $clog2(N_SRC);
  localparam int SPW    = 8;                      // sources per level word
  localparam int DW     = SPW * LVL_W;
  localparam int N_LW   = (N_SRC + SPW - 1) / SPW;
  localparam int AW     = $clog2(N_LW + 1);
  localparam int ID_EXT0 = 1;
  localparam int ID_INT0 = 1 + N_EXT;
endpackage

// File: rtl/pic_sync.sv
`timescale 1ns/1ps
module pic_sync #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pic_regs.sv
`timescale 1ns/1ps
module pic_regs
  import pic_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [NS-1:0]            en_o,
  output logic [NS-1:0][LVL_W-1:0] lvl_o
);
  logic [NS-1:0]            en_q;
  logic [NS-1:0][LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i && addr_i == '0) begin
      en_q <= wdata_i[NS-1:0];
    end
  end

  for (genvar j = 0; j < NS; j++) begin : g_lvl
    localparam int WORD = 1 + j / SPW;
    localparam int POS  = (j % SPW) * LVL_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[j] <= '0;
      else if (we_i && int'(addr_i) == WORD) lvl_q[j] <= wdata_i[POS +: LVL_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[NS-1:0] = en_q;
    end else begin
      for (int j = 0; j < NS; j++) begin
        if (int'(addr_i) == 1 + j / SPW) rdata_o[(j % SPW) * LVL_W +: LVL_W] = lvl_q[j];
      end
    end
  end

  assign en_o  = en_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/pic_pending.sv
`timescale 1ns/1ps
module pic_pending
  import pic_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NE = N_EXT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS-1:0]   req_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  output logic [NS-1:0]   pend_o
);
  for (genvar j = 0; j < NS; j++) begin : g_src
    if (j >= ID_EXT0 && j < ID_EXT0 + NE) begin : g_edge
      logic prev_q, pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= req_i[j];
          if (req_i[j] && !prev_q)                        pend_q <= 1'b1;
          else if (clr_i && clr_id_i == ID_W'(j))         pend_q <= 1'b0;
        end
      end
      assign pend_o[j] = pend_q;
    end else begin : g_level
      assign pend_o[j] = req_i[j];
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic [NS-1:0]            req_i,
  input  logic [NS-1:0][LVL_W-1:0] lvl_i,
  input  logic                     thr_valid_i,
  input  logic [LVL_W-1:0]         thr_i,
  output logic                     valid_o,
  output logic [ID_W-1:0]          id_o
);
  logic [LVL_W-1:0] best_lvl;

  // descending scan with >= lets the lower index take ties
  always_comb begin
    valid_o  = 1'b0;
    best_lvl = '0;
    id_o     = '0;
    for (int j = NS - 1; j >= 0; j--) begin
      if (req_i[j] && (!thr_valid_i || lvl_i[j] > thr_i) &&
          (!valid_o || lvl_i[j] >= best_lvl)) begin
        valid_o  = 1'b1;
        best_lvl = lvl_i[j];
        id_o     = ID_W'(j);
      end
    end
  end
endmodule

// File: rtl/pic_lvl_stack.sv
`timescale 1ns/1ps
module pic_lvl_stack
  import pic_pkg::*;
#(
  parameter int NL = N_LVL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [NL-1:0]    act_o,
  output logic             busy_o,
  output logic [LVL_W-1:0] cur_o
);
  logic [NL-1:0] act_q, act_d;

  always_comb begin
    cur_o = '0;
    for (int l = 0; l < NL; l++) if (act_q[l]) cur_o = LVL_W'(l);
  end

  assign busy_o = |act_q;

  // nesting only ever pushes strictly higher levels, so a bit mask is a full stack
  always_comb begin
    act_d = act_q;
    if (pop_i && busy_o) act_d[cur_o] = 1'b0;
    if (push_i)          act_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fiq_req_i,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic             fiq_o,
  input  logic             ack_i,
  input  logic             eoi_i
);
  logic [N_SRC-1:0]            raw, sync_req, pend, en, arb_req;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [N_LVL-1:0]            act_mask;
  logic                        busy, take;
  logic [LVL_W-1:0]            cur_lvl;

  assign raw = {int_req_i, ext_req_i, fiq_req_i};

  pic_sync #(.W(N_SRC)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(sync_req)
  );

  pic_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .en_o(en), .lvl_o(lvl)
  );

  assign take = ack_i & irq_o;

  pic_pending u_pend (
    .clk_i, .rst_ni, .req_i(sync_req), .clr_i(take), .clr_id_i(irq_id_o), .pend_o(pend)
  );

  assign arb_req = {pend[N_SRC-1:1] & en[N_SRC-1:1], 1'b0};

  pic_arbiter u_arb (
    .req_i(arb_req), .lvl_i(lvl), .thr_valid_i(busy), .thr_i(cur_lvl),
    .valid_o(irq_o), .id_o(irq_id_o)
  );

  pic_lvl_stack u_stack (
    .clk_i, .rst_ni, .push_i(take), .push_lvl_i(lvl[irq_id_o]), .pop_i(eoi_i),
    .act_o(act_mask), .busy_o(busy), .cur_o(cur_lvl)
  );

  assign fiq_o = pend[0] & en[0];
endmodule

// File: rtl/pic_ctrl_chk.sv
`timescale 1ns/1ps
module pic_ctrl_chk
  import pic_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [ID_W-1:0]  irq_id_o,
  input logic             ack_i,
  input logic             eoi_i,
  input logic [N_LVL-1:0] act_i
);
  assert_id_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_id_o >= ID_W'(ID_EXT0) && irq_id_o < ID_W'(N_SRC)));

  assert_ack_masks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !(irq_o && irq_id_o == $past(irq_id_o)));

  assert_ack_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !eoi_i) |=> (act_i != '0));

  assert_eoi_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && act_i != '0) |=> ($countones(act_i) == $countones($past(act_i)) - 1));

  assert_idle_ack_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_i) |=> $stable(act_i));

  assert_eoi_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && act_i == '0 && !(ack_i && irq_o)) |=> (act_i == '0));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .irq_id_o(irq_id_o),
  .ack_i(ack_i), .eoi_i(eoi_i), .act_i(act_mask)
);

// File: tb/pic_ctrl_bench.sv
`timescale 1ns/1ps
module pic_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fiq_req_i = 1'b0;
  logic [3:0]  ext_req_i = '0;
  logic [18:0] int_req_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [23:0] reg_wdata_i = '0;
  logic [23:0] reg_rdata_o;
  logic        irq_o, fiq_o;
  logic [4:0]  irq_id_o;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;

  int vectors = 0;
  int errors  = 0;
  int mon_done = 0;
  logic [6:0] q_exp[$];
  string      q_tag[$];

  always #2 clk_i = ~clk_i;

  pic_ctrl u_pic_ctrl (
    .clk_i, .rst_ni, .fiq_req_i, .ext_req_i, .int_req_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .irq_o, .irq_id_o, .fiq_o, .ack_i, .eoi_i
  );

  // monitor: pops expected {fiq, irq, id} and compares with the outputs
  initial begin
    forever begin
      wait (q_exp.size() != 0);
      #0.5;
      begin
        logic [6:0] e;
        logic [6:0] a;
        string      t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {fiq_o, irq_o, irq_o ? irq_id_o : 5'd0};
        vectors++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: fiq/irq/id actual %0b/%0b/%0d expected %0b/%0b/%0d",
                   t, a[6], a[5], a[4:0], e[6], e[5], e[4:0]);
        end
      end
      mon_done++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_out(input logic f, input logic i, input logic [4:0] id, input string tag);
    int tgt;
    tgt = mon_done + 1;
    q_exp.push_back({f, i, i ? id : 5'd0});
    q_tag.push_back(tag);
    wait (mon_done == tgt);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [23:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_chk(input logic [1:0] a, input logic [23:0] e, input string tag);
    reg_addr_i = a;
    #0.5;
    vectors++;
    if (reg_rdata_o !== e) begin
      errors++;
      $display("FAIL %s: word %0d actual %h expected %h", tag, a, reg_rdata_o, e);
    end
    step(1);
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi_i = 1'b1; step(1); eoi_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    expect_out(0, 0, 0, "R1 outputs");
    reg_chk(2'd0, 24'h0, "R1 enable");
    reg_chk(2'd1, 24'h0, "R1 level");

    // R2 register map: id1=3, id5=2, id6=5, id7=5, id9=7, id8=0
    reg_wr(2'd0, 24'hFFFFFF);
    reg_wr(2'd1, 24'hB50018);
    reg_wr(2'd2, 24'h000038);
    reg_chk(2'd0, 24'hFFFFFF, "R2 enable");
    reg_chk(2'd1, 24'hB50018, "R2 level word1");
    reg_chk(2'd2, 24'h000038, "R2 level word2");
    reg_chk(2'd3, 24'h000000, "R2 level word3");

    // R11 internal latency
    int_req_i[0] = 1'b1;
    step(1); expect_out(0, 0, 0, "R11 internal edge1");
    step(1); expect_out(0, 1, 5, "R11 internal edge2");

    // R4 higher level wins, R5 equal level lower id
    int_req_i[1] = 1'b1; step(3); expect_out(0, 1, 6, "R4 higher level");
    int_req_i[2] = 1'b1; step(3); expect_out(0, 1, 6, "R5 tie lower id");
    int_req_i[1] = 1'b0; step(3); expect_out(0, 1, 7, "R5 remaining");
    // R8 level withdrawal
    int_req_i[2] = 1'b0; step(3); expect_out(0, 1, 5, "R8 withdraw");
    int_req_i[0] = 1'b0; step(3); expect_out(0, 0, 0, "R8 none");

    // R3 disabled source
    reg_wr(2'd0, 24'hFFFFDF);
    int_req_i[0] = 1'b1; step(4); expect_out(0, 0, 0, "R3 disabled");
    reg_wr(2'd0, 24'hFFFFFF); expect_out(0, 1, 5, "R3 reenabled");
    int_req_i[0] = 1'b0; step(3); expect_out(0, 0, 0, "R3 idle");

    // R7 / R11 external edge latch
    ext_req_i[0] = 1'b1;
    step(2); expect_out(0, 0, 0, "R11 external edge2");
    step(1); expect_out(0, 1, 1, "R11 external edge3");
    ext_req_i[0] = 1'b0; step(3); expect_out(0, 1, 1, "R7 latched");
    pulse_ack(); expect_out(0, 0, 0, "R7 cleared by ack");
    pulse_eoi(); expect_out(0, 0, 0, "R7 stays clear");
    ext_req_i[0] = 1'b1; step(3); expect_out(0, 1, 1, "R7 held high");
    pulse_ack(); pulse_eoi(); step(2); expect_out(0, 0, 0, "R7 no repeat");
    ext_req_i[0] = 1'b0; step(3);

    // R9 / R10 nesting
    int_req_i[0] = 1'b1; step(3); expect_out(0, 1, 5, "R9 first");
    pulse_ack(); expect_out(0, 0, 0, "R9 own level masked");
    int_req_i[1] = 1'b1; step(3); expect_out(0, 1, 6, "R9 preempt");
    pulse_ack(); expect_out(0, 0, 0, "R9 nested masked");
    int_req_i[2] = 1'b1; step(3); expect_out(0, 0, 0, "R9 equal masked");
    pulse_eoi(); expect_out(0, 1, 6, "R10 pop to level2");
    int_req_i[1] = 1'b0; step(3); expect_out(0, 1, 7, "R10 next");
    int_req_i[2] = 1'b0; step(3); expect_out(0, 0, 0, "R10 low masked");
    pulse_eoi(); expect_out(0, 1, 5, "R10 pop to none");
    int_req_i[0] = 1'b0; step(3); expect_out(0, 0, 0, "R10 idle");

    // R12 stray ack / eoi: id8 at level 0 would be masked by any push
    pulse_ack();
    int_req_i[3] = 1'b1; step(3); expect_out(0, 1, 8, "R12 stray ack");
    pulse_eoi(); expect_out(0, 1, 8, "R12 stray eoi");
    int_req_i[3] = 1'b0; step(3); expect_out(0, 0, 0, "R12 idle");

    // R6 fast path
    fiq_req_i = 1'b1;
    step(1); expect_out(0, 0, 0, "R6 edge1");
    step(1); expect_out(1, 0, 0, "R6 edge2");
    int_req_i[4] = 1'b1; step(3); expect_out(1, 1, 9, "R6 independent");
    pulse_ack(); expect_out(1, 0, 0, "R6 unaffected by stack");
    reg_wr(2'd0, 24'hFFFFFE); expect_out(0, 0, 0, "R6 disabled");
    pulse_eoi(); int_req_i[4] = 1'b0; fiq_req_i = 1'b0; step(3);
    expect_out(0, 0, 0, "R6 idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule